// File: doc/BRIEF.md
# Power-Up Configuration Loader

This block runs once each time the terminal's master clear is released. On the rising edge of the active-low master clear it either applies a fixed set of six option enables, all set, or fetches them from an external data bus with a single read transfer. The read uses a request/grant handshake. The block lowers its request line and waits for the active-low grant. It then holds its acknowledge and active lines low for one clock while it samples the low six data bits. It releases the request on the next clock. If the grant line is wired low, the handshake costs no wait, and acknowledge follows request by one clock.

Once the options are latched, the block may start an external self-test, which reports back with a done strobe and a pass flag. It then decides whether to raise the online enable. An option bit set to 1 means the option is enabled.

| Bit | Option |
|-----|--------|
| 0 | protocol revision select (1 = revision B) |
| 1 | self-test enable |
| 2 | burst transfer of received words |
| 3 | subaddress-30 loop storage |
| 4 | terminal-flag on loop failure |
| 5 | go online even if the self-test fails |

Dropping master clear low at any point abandons the sequence, and the next rising edge starts it again from the beginning.

Top module: `autocfg_loader`

## Requirements
- R1: While reset is held and after its release, `req_n`, `ack_n` and `act_n` are 1, `online_en` and `st_start` are 0, and `cfg_o` is 6'h3F.
- R2: With `cfg_strap` at 1 on the master-clear rising edge, `req_n` stays 1. On the next clock, `cfg_o` holds 6'h3F whatever `data_in` is.
- R3: With `cfg_strap` at 0, `req_n` goes low the clock after the rising edge of `mclr_n`. It stays low, with `ack_n` high, until `grant_n` is sampled low.
- R4: `ack_n` and `act_n` go low together for exactly one clock, starting the clock after `grant_n` is sampled low while `req_n` is low. With `grant_n` tied low, this is one clock after `req_n` falls.
- R5: `cfg_o` takes `data_in[5:0]` as sampled at the clock edge that ends the acknowledge cycle, with bit 1 as self-test enable and bit 5 as online-on-failure. Data present at any other time has no effect on `cfg_o`.
- R6: `req_n` returns to 1 on the clock that follows the acknowledge cycle.
- R7: If the loaded bit 1 is 0, `online_en` is 1 on the clock after the load, and `st_start` never pulses.
- R8: If the loaded bit 1 is 1, `st_start` is a one-clock pulse on the clock after the load. `online_en` stays 0 until `st_done` is seen.
- R9: When `st_done` is sampled at 1 during the self-test wait, `online_en` becomes `st_pass` OR loaded bit 5 on the next clock.
- R10: `mclr_n` at 0 makes `req_n`, `ack_n` and `act_n` 1 and `online_en` and `st_start` 0 from the next clock, and a later `st_done` has no effect. The next rising edge restarts the whole sequence.
- R11: `mclr_n` held high with no rising edge since reset starts no sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| mclr_n | input | 1 | active-low master clear; release starts a load |
| cfg_strap | input | 1 | 1 = apply all-enabled defaults, 0 = read options from the bus |
| grant_n | input | 1 | active-low bus grant |
| data_in | input | 6 | option bits read during the acknowledge cycle |
| st_done | input | 1 | self-test finished strobe |
| st_pass | input | 1 | self-test result, 1 = passed |
| req_n | output | 1 | active-low bus request |
| ack_n | output | 1 | active-low transfer acknowledge |
| act_n | output | 1 | active-low transfer active |
| st_start | output | 1 | one-clock self-test start pulse |
| cfg_o | output | 6 | latched option enables |
| online_en | output | 1 | terminal online enable |

## Verification
The checker watches the handshake shape on every clock:
- acknowledge and active move as a pair, last one clock, and only fall inside a request that was granted;
- request lifts right after the acknowledge cycle;
- the option register equals the bus data from the acknowledge edge;
- the start pulse is one clock wide;
- a low master clear silences every output.

The online verdict after `st_done` is also checked on every clock, against pass and bit 5. Only the bench's scenarios can show the following:
- that the wait before acknowledge tracks a grant delayed by several clocks;
- that the default path never requests;
- that `st_done` arriving after an abort is ignored;
- that a release with no preceding low level starts nothing.

// File: rtl/autocfg_pkg.sv
package autocfg_pkg;

  localparam int CFG_W     = 6;
  localparam int B_PROTO   = 0;
  localparam int B_STEN    = 1;
  localparam int B_BURST   = 2;
  localparam int B_WRAP    = 3;
  localparam int B_TFLAG   = 4;
  localparam int B_ONFAIL  = 5;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_REQ    = 3'd1,
    S_ACK    = 3'd2,
    S_TSTART = 3'd3,
    S_TWAIT  = 3'd4,
    S_DONE   = 3'd5
  } seq_state_e;

  // every option defaults to enabled, revision B protocol included
  function automatic logic [CFG_W-1:0] default_cfg();
    return {CFG_W{1'b1}};
  endfunction

  function automatic logic wants_test(input logic [CFG_W-1:0] c);
    return c[B_STEN];
  endfunction

  function automatic logic online_verdict(input logic [CFG_W-1:0] c,
                                          input logic             pass);
    return pass | c[B_ONFAIL];
  endfunction

  function automatic logic [CFG_W-1:0] pick_cfg(input logic             use_dflt,
                                                input logic [CFG_W-1:0] bus);
    return use_dflt ? default_cfg() : bus;
  endfunction

endpackage

// File: rtl/cfgld_mclr_edge.sv
module cfgld_mclr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic mclr_n,
  output logic rise,
  output logic hold
);

  logic mclr_q;

  // reset to high so that a high level at reset release is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mclr_q <= 1'b1;
    else        mclr_q <= mclr_n;
  end

  assign rise = mclr_n & ~mclr_q;
  assign hold = ~mclr_n;

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import autocfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic rise,
  input  logic strap,
  input  logic grant_n,
  input  logic bus_test_en,
  input  logic st_done,
  output logic req_n,
  output logic ack_n,
  output logic act_n,
  output logic st_start,
  output logic load_bus,
  output logic load_dflt,
  output logic decide
);

  seq_state_e state_q, state_d;
  logic       dflt_test;

  assign dflt_test = wants_test(default_cfg());

  assign load_dflt = rise & strap;
  assign load_bus  = (state_q == S_ACK) & ~hold;
  assign decide    = (state_q == S_TWAIT) & ~hold & st_done;

  always_comb begin
    state_d = state_q;
    if (hold) begin
      state_d = S_IDLE;
    end else if (rise) begin
      if (strap) state_d = dflt_test ? S_TSTART : S_DONE;
      else       state_d = S_REQ;
    end else begin
      unique case (state_q)
        S_REQ:    if (!grant_n) state_d = S_ACK;
        S_ACK:    state_d = bus_test_en ? S_TSTART : S_DONE;
        S_TSTART: state_d = S_TWAIT;
        S_TWAIT:  if (st_done) state_d = S_DONE;
        S_IDLE:   state_d = S_IDLE;
        S_DONE:   state_d = S_DONE;
        default:  state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // outputs decoded straight from the state register
  assign req_n    = ~((state_q == S_REQ) | (state_q == S_ACK));
  assign ack_n    = (state_q != S_ACK);
  assign act_n    = (state_q != S_ACK);
  assign st_start = (state_q == S_TSTART);

endmodule

// File: rtl/cfgld_cfgreg.sv
module cfgld_cfgreg
  import autocfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] load_val,
  output logic [CFG_W-1:0] cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= default_cfg();
    else if (load) cfg_q <= load_val;
  end

endmodule

// File: rtl/cfgld_online.sv
module cfgld_online
  import autocfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             rise,
  input  logic             set_direct,
  input  logic             decide,
  input  logic             pass,
  input  logic [CFG_W-1:0] cfg_q,
  output logic             online
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          online <= 1'b0;
    else if (hold)       online <= 1'b0;
    else if (set_direct) online <= 1'b1;
    else if (rise)       online <= 1'b0;
    else if (decide)     online <= online_verdict(cfg_q, pass);
  end

endmodule

// File: rtl/autocfg_loader.sv
module autocfg_loader
  import autocfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mclr_n,
  input  logic             cfg_strap,
  input  logic             grant_n,
  input  logic [CFG_W-1:0] data_in,
  input  logic             st_done,
  input  logic             st_pass,
  output logic             req_n,
  output logic             ack_n,
  output logic             act_n,
  output logic             st_start,
  output logic [CFG_W-1:0] cfg_o,
  output logic             online_en
);

  // named internal events, also observed by the checker
  logic             start_rise;
  logic             mclr_hold;
  logic             load_bus;
  logic             load_dflt;
  logic             load_evt;
  logic             decide;
  logic [CFG_W-1:0] loaded_val;

  cfgld_mclr_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .mclr_n (mclr_n),
    .rise   (start_rise),
    .hold   (mclr_hold)
  );

  cfgld_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (mclr_hold),
    .rise        (start_rise),
    .strap       (cfg_strap),
    .grant_n     (grant_n),
    .bus_test_en (wants_test(data_in)),
    .st_done     (st_done),
    .req_n       (req_n),
    .ack_n       (ack_n),
    .act_n       (act_n),
    .st_start    (st_start),
    .load_bus    (load_bus),
    .load_dflt   (load_dflt),
    .decide      (decide)
  );

  assign loaded_val = pick_cfg(load_dflt, data_in);
  assign load_evt   = load_bus | load_dflt;

  cfgld_cfgreg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .load_val (loaded_val),
    .cfg_q    (cfg_o)
  );

  cfgld_online u_online (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (mclr_hold),
    .rise       (start_rise),
    .set_direct (load_evt & ~wants_test(loaded_val)),
    .decide     (decide),
    .pass       (st_pass),
    .cfg_q      (cfg_o),
    .online     (online_en)
  );

endmodule

// File: rtl/autocfg_loader_chk.sv
module autocfg_loader_chk
  import autocfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mclr_n,
  input logic             cfg_strap,
  input logic             grant_n,
  input logic [CFG_W-1:0] data_in,
  input logic             st_pass,
  input logic             req_n,
  input logic             ack_n,
  input logic             act_n,
  input logic             st_start,
  input logic [CFG_W-1:0] cfg_o,
  input logic             online_en,
  input logic             start_rise,
  input logic             decide
);

  // R2: the default path never requests and loads all ones
  p_default_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise && cfg_strap |=> req_n && (cfg_o == {CFG_W{1'b1}}));

  // R3: acknowledge only after a granted request
  p_ack_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(!grant_n) && $past(!req_n));

  // R4: acknowledge and active travel together
  p_ack_act_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n == act_n);

  // R4: acknowledge lasts one clock
  p_ack_one_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> ack_n);

  // R4: acknowledge always within a request
  p_ack_in_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !req_n);

  // R5: the register holds the bus value from the acknowledge edge
  p_bus_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n && mclr_n |=> cfg_o == $past(data_in));

  // R6: request lifts right after acknowledge
  p_req_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> req_n);

  // R7: no self-test, straight online
  p_direct_online_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n && mclr_n && !data_in[B_STEN] |=> online_en && !st_start);

  // R8: self-test start after loading an enabled test
  p_test_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n && mclr_n && data_in[B_STEN] |=> st_start && !online_en);

  // R8: the start pulse is one clock wide
  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_start |=> !st_start);

  // R9: verdict after self-test completes
  p_verdict_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    decide && st_pass |=> online_en);

  p_verdict_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    decide && !st_pass && !cfg_o[B_ONFAIL] |=> !online_en);

  // R10: master clear low silences every output
  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mclr_n |=> req_n && ack_n && act_n && !st_start && !online_en);

endmodule

bind autocfg_loader autocfg_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mclr_n     (mclr_n),
  .cfg_strap  (cfg_strap),
  .grant_n    (grant_n),
  .data_in    (data_in),
  .st_pass    (st_pass),
  .req_n      (req_n),
  .ack_n      (ack_n),
  .act_n      (act_n),
  .st_start   (st_start),
  .cfg_o      (cfg_o),
  .online_en  (online_en),
  .start_rise (start_rise),
  .decide     (decide)
);

// File: tb/autocfg_loader_test.sv
`timescale 1ns/1ps
module autocfg_loader_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mclr_n;
  logic       cfg_strap;
  logic       grant_n;
  logic [5:0] data_in;
  logic       st_done;
  logic       st_pass;
  logic       req_n, ack_n, act_n, st_start, online_en;
  logic [5:0] cfg_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  autocfg_loader uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclr_n    (mclr_n),
    .cfg_strap (cfg_strap),
    .grant_n   (grant_n),
    .data_in   (data_in),
    .st_done   (st_done),
    .st_pass   (st_pass),
    .req_n     (req_n),
    .ack_n     (ack_n),
    .act_n     (act_n),
    .st_start  (st_start),
    .cfg_o     (cfg_o),
    .online_en (online_en)
  );

  // {strap, grant delay[2:0], data[5:0], pass, test delay[2:0]}
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 3'd0, 6'h00, 1'b0, 3'd2},
    {1'b0, 3'd0, 6'h00, 1'b0, 3'd0},
    {1'b0, 3'd3, 6'h2A, 1'b0, 3'd1},
    {1'b0, 3'd1, 6'h02, 1'b0, 3'd1},
    {1'b0, 3'd2, 6'h03, 1'b1, 3'd0},
    {1'b0, 3'd0, 6'h15, 1'b0, 3'd0},
    {1'b0, 3'd5, 6'h3F, 1'b0, 3'd2},
    {1'b0, 3'd0, 6'h1E, 1'b0, 3'd3}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_vec(input logic strap, input int gd, input logic [5:0] d,
                         input logic pass, input int sd);
    logic [5:0] ec;
    logic       eo;
    ec = strap ? 6'h3F : d;
    eo = ec[1] ? (pass | ec[5]) : 1'b1;
    @(negedge clk);
    mclr_n = 1'b0; cfg_strap = strap; grant_n = (gd == 0) ? 1'b0 : 1'b1;
    data_in = ~d; st_done = 1'b0; st_pass = ~pass;
    @(negedge clk);
    check(req_n && ack_n && !online_en, "R10", {req_n, ack_n, online_en}, 3'b110);
    mclr_n = 1'b1;
    data_in = strap ? d : ~d;
    @(negedge clk);
    if (strap) begin
      check(req_n == 1'b1, "R2", req_n, 1);
      check(cfg_o == 6'h3F, "R2", cfg_o, 6'h3F);
    end else begin
      check(req_n == 1'b0, "R3", req_n, 0);
      for (int i = 0; i < gd; i++) begin
        check(ack_n && !req_n, "R3", {ack_n, req_n}, 2'b10);
        @(negedge clk);
      end
      grant_n = 1'b0; data_in = d;
      @(negedge clk);
      check(!ack_n && !act_n && !req_n, "R4", {ack_n, act_n, req_n}, 0);
      @(negedge clk);
      check(cfg_o == d, "R5", cfg_o, d);
      check(req_n && ack_n, "R6", {req_n, ack_n}, 2'b11);
      data_in = ~d; grant_n = 1'b1;
    end
    if (!ec[1]) begin
      check(online_en && !st_start, "R7", {online_en, st_start}, 2'b10);
    end else begin
      check(st_start && !online_en, "R8", {st_start, online_en}, 2'b10);
      for (int i = 0; i <= sd; i++) begin
        @(negedge clk);
        check(!st_start && !online_en, "R8", {st_start, online_en}, 0);
      end
      st_done = 1'b1; st_pass = pass;
      @(negedge clk);
      st_done = 1'b0;
      check(online_en == eo, "R9", online_en, eo);
    end
    @(negedge clk);
    check(cfg_o == ec, "R5", cfg_o, ec);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mclr_n = 1'b1; cfg_strap = 1'b0; grant_n = 1'b0;
    data_in = 6'h00; st_done = 1'b0; st_pass = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_n && ack_n && act_n && !online_en && !st_start, "R1",
          {req_n, ack_n, act_n, online_en, st_start}, 5'b11100);
    check(cfg_o == 6'h3F, "R1", cfg_o, 6'h3F);
    rst_n = 1'b1;
    // R11: high level with no edge starts nothing
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(req_n && ack_n && !st_start && !online_en, "R11",
            {req_n, ack_n, st_start, online_en}, 4'b1100);
    end
    check(cfg_o == 6'h3F, "R1", cfg_o, 6'h3F);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][13], int'(VEC[v][12:10]), VEC[v][9:4], VEC[v][3], int'(VEC[v][2:0]));

    // R10: abort while waiting for the grant, then restart
    @(negedge clk);
    mclr_n = 1'b0; cfg_strap = 1'b0; grant_n = 1'b1;
    @(negedge clk);
    mclr_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!req_n, "R3", req_n, 0);
    mclr_n = 1'b0; grant_n = 1'b0;
    @(negedge clk);
    check(req_n && ack_n && act_n, "R10", {req_n, ack_n, act_n}, 3'b111);
    run_vec(1'b0, 0, 6'h01, 1'b0, 0);

    // R10: abort during the self-test wait, late done ignored
    @(negedge clk);
    mclr_n = 1'b0; cfg_strap = 1'b1;
    @(negedge clk);
    mclr_n = 1'b1;
    repeat (3) @(negedge clk);
    mclr_n = 1'b0;
    @(negedge clk);
    check(!online_en && !st_start, "R10", {online_en, st_start}, 0);
    st_done = 1'b1; st_pass = 1'b1;
    @(negedge clk);
    st_done = 1'b0;
    @(negedge clk);
    check(!online_en, "R10", online_en, 0);
    mclr_n = 1'b1;
    @(negedge clk);
    check(st_start && req_n, "R10", {st_start, req_n}, 2'b11);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule